// File: doc/BRIEF.md
# Streaming Link Frame Builder

This block takes 32-bit words from a first-word-fall-through transmit FIFO and wraps them into frames for a serial streaming link. Its output is one 32-bit word per clock with a four-bit flag that marks the bytes an 8B/10B encoder must send as control characters. A frame opens with a start ordered set and carries up to 512 payload words. A trailer follows the payload: a type word, a CRC word and an end ordered set. Two idle ordered sets close the frame, so every frame costs six words of overhead. Idle ordered sets also fill the line whenever no frame is in progress.

There are three kinds of frame. A plain data frame closes when it reaches the 512-word limit. A sync frame closes once a sync request is pending and the FIFO has run dry. A bare sync frame carries no payload and is sent when a sync request arrives while no frame is open and the FIFO is empty. Together these carry the parallel port's sync signalling across the link. A stop indication from the far end holds off the start of new frames. A frame that is already open still runs to its end.

Top module: `sfb_frame_builder`

## Requirements
- R1: While reset is held, the output is the idle ordered set (word 32'h9595_B5BC, control flags 4'b0001) and no FIFO word is popped.
- R2: With the FIFO empty and no sync pending, the output is the idle ordered set on every cycle and nothing is popped.
- R3: A frame is sent as follows, in order: the start ordered set (32'h3737_B5BC), the payload in FIFO order, the type word, the CRC word, the end ordered set (32'hF5F5_95BC), then exactly two idle ordered sets.
- R4: The type word has the payload count in bits 31:16, zeros in bits 15:2 and the kind in bits 1:0. Kind 1 is data, 2 is sync and 3 is bare sync.
- R5: The CRC word is the bitwise inverse of a CRC-32 (polynomial 32'h04C11DB7, seed 32'hFFFF_FFFF, each word fed MSB first) taken over the payload words and then the type word.
- R6: A frame that reaches 512 payload words closes as kind 1. FIFO words still waiting go into the next frame.
- R7: A sync request is a one-cycle pulse that stays pending until it is consumed. It closes the open frame as kind 2 on the first cycle the FIFO is empty, and is consumed when that frame's type word is sent.
- R8: A sync request that arrives with no frame open and an empty FIFO produces a frame with no payload and kind 3.
- R9: If the FIFO runs dry inside a frame and no sync is pending, idle ordered sets are sent inside the frame and the frame stays open for more payload.
- R10: While far_stop is high, no new frame starts. A frame already open runs to completion.
- R11: Payload, type and CRC words carry control flags 4'b0000. Ordered sets carry 4'b0001, with the control character in byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_empty | input | 1 | Transmit FIFO holds no word |
| fifo_data | input | 32 | Head word of the transmit FIFO |
| fifo_pop | output | 1 | Consume the head word this cycle |
| sync_req | input | 1 | One-cycle request to end the stream segment with sync |
| far_stop | input | 1 | Far end asks that no new frame be started |
| tx_data | output | 32 | Word to the 8B/10B encoder |
| tx_ctrl | output | 4 | Per-byte control-character flags |

## Verification
The framing is driven with FIFO loads of 0, 1, 5, 512, 600 and 1024 words, with and without a sync request. These loads tell apart the three ways a frame can close: at the word limit, on sync with an empty FIFO, and with no payload at all. The 600- and 1024-word loads show that a full frame hands its leftover words to the next one. A load that pauses mid-frame separates in-frame idle filling from a premature close. Holding the stop input before a frame and during a frame checks that it blocks only frame starts.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BODY,
        ST_TYPE,
        ST_CRC,
        ST_EOF,
        ST_GAP
    } fsm_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_DATA = 2'd1,
        KIND_SYNC = 2'd2,
        KIND_BARE = 2'd3
    } kind_e;

    // Ordered sets: comma character in byte 0, data characters above it
    localparam logic [WORD_W-1:0] OS_IDLE = 32'h9595_B5BC;
    localparam logic [WORD_W-1:0] OS_SOF  = 32'h3737_B5BC;
    localparam logic [WORD_W-1:0] OS_EOF  = 32'hF5F5_95BC;
    localparam logic [LANES-1:0]  K_OS    = 4'b0001;
    localparam logic [LANES-1:0]  K_DATA  = 4'b0000;

    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
endpackage

// File: rtl/sfb_crc_step.sv
module sfb_crc_step
    import sfb_pkg::*;
#(
    parameter int DIN_W = WORD_W
) (
    input  logic [WORD_W-1:0] crc_in,
    input  logic [DIN_W-1:0]  din,
    output logic [WORD_W-1:0] crc_out
);
    always_comb begin
        logic [WORD_W-1:0] acc;
        logic              fb;
        acc = crc_in;
        for (int b = DIN_W - 1; b >= 0; b--) begin
            fb  = acc[WORD_W-1] ^ din[b];
            acc = {acc[WORD_W-2:0], 1'b0};
            if (fb) acc = acc ^ CRC_POLY;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/sfb_type_word.sv
module sfb_type_word
    import sfb_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0]  count,
    input  kind_e             kind,
    output logic [WORD_W-1:0] word
);
    localparam int PAD_W = WORD_W - 16 - 2;
    assign word = {16'(count), {PAD_W{1'b0}}, kind};
endmodule

// File: rtl/sfb_frame_builder.sv
module sfb_frame_builder
    import sfb_pkg::*;
#(
    parameter int MAX_WORDS = 512,
    parameter int GAP_WORDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [31:0]       fifo_data,
    output logic              fifo_pop,
    input  logic              sync_req,
    input  logic              far_stop,
    output logic [31:0]       tx_data,
    output logic [3:0]        tx_ctrl
);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);
    localparam int GAP_W = (GAP_WORDS > 1) ? $clog2(GAP_WORDS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_WORDS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAX_WORDS);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_WORDS - 1);

    typedef struct packed {
        fsm_e              state;
        kind_e             kind;
        logic [CNT_W-1:0]  cnt;
        logic [GAP_W-1:0]  gap;
        logic              pend;
        logic [WORD_W-1:0] crc;
        logic [WORD_W-1:0] out_data;
        logic [LANES-1:0]  out_ctrl;
    } regs_t;

    regs_t r_d, r_q;

    logic [WORD_W-1:0] crc_din;
    logic [WORD_W-1:0] crc_next;
    logic [WORD_W-1:0] type_word;
    kind_e             type_kind;
    logic              pop_c;

    // Type kind: closing straight from the body is always a sync close
    assign type_kind = (r_q.state == ST_BODY) ? KIND_SYNC : r_q.kind;
    assign pop_c     = (r_q.state == ST_BODY) && !fifo_empty;
    assign crc_din   = pop_c ? fifo_data : type_word;

    sfb_type_word #(.CNT_W(CNT_W)) u_type (
        .count (r_q.cnt),
        .kind  (type_kind),
        .word  (type_word)
    );

    sfb_crc_step #(.DIN_W(WORD_W)) u_crc (
        .crc_in  (r_q.crc),
        .din     (crc_din),
        .crc_out (crc_next)
    );

    always_comb begin
        logic clr_pend;
        r_d          = r_q;
        r_d.out_data = OS_IDLE;
        r_d.out_ctrl = K_OS;
        clr_pend     = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (!far_stop && (!fifo_empty || r_q.pend)) begin
                    r_d.out_data = OS_SOF;
                    r_d.cnt      = '0;
                    r_d.crc      = CRC_SEED;
                    if (fifo_empty) begin
                        r_d.kind  = KIND_BARE;
                        r_d.state = ST_TYPE;
                    end else begin
                        r_d.kind  = KIND_NONE;
                        r_d.state = ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                if (pop_c) begin
                    r_d.out_data = fifo_data;
                    r_d.out_ctrl = K_DATA;
                    r_d.crc      = crc_next;
                    r_d.cnt      = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_LAST) begin
                        r_d.kind  = KIND_DATA;
                        r_d.state = ST_TYPE;
                    end
                end else if (r_q.pend) begin
                    r_d.out_data = type_word;
                    r_d.out_ctrl = K_DATA;
                    r_d.crc      = crc_next;
                    r_d.kind     = KIND_SYNC;
                    r_d.state    = ST_CRC;
                    clr_pend     = 1'b1;
                end
            end
            ST_TYPE: begin
                r_d.out_data = type_word;
                r_d.out_ctrl = K_DATA;
                r_d.crc      = crc_next;
                r_d.state    = ST_CRC;
                clr_pend     = (r_q.kind != KIND_DATA);
            end
            ST_CRC: begin
                r_d.out_data = ~r_q.crc;
                r_d.out_ctrl = K_DATA;
                r_d.state    = ST_EOF;
            end
            ST_EOF: begin
                r_d.out_data = OS_EOF;
                r_d.gap      = '0;
                r_d.state    = ST_GAP;
            end
            ST_GAP: begin
                r_d.gap = r_q.gap + 1'b1;
                if (r_q.gap == GAP_LAST) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase

        r_d.pend = (r_q.pend && !clr_pend) || sync_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.kind     <= KIND_NONE;
            r_q.crc      <= CRC_SEED;
            r_q.out_data <= OS_IDLE;
            r_q.out_ctrl <= K_OS;
        end else begin
            r_q <= r_d;
        end
    end

    assign fifo_pop = pop_c;
    assign tx_data  = r_q.out_data;
    assign tx_ctrl  = r_q.out_ctrl;

    // A pop must find a word in the FIFO
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // A popped word leaves as plain data
    assert_payload_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (tx_ctrl == K_DATA));

    // Payload count never passes the frame limit
    assert_cnt_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_FULL);

    // End ordered set is always followed by an idle
    assert_eof_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctrl == K_OS && tx_data == OS_EOF) |=> (tx_ctrl == K_OS && tx_data == OS_IDLE));

    // Stop from the far end keeps a waiting builder from opening a frame
    assert_stop_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && far_stop) |=> !(tx_ctrl == K_OS && tx_data == OS_SOF));
endmodule

// File: tb/sfb_frame_builder_test.sv
`timescale 1ns/1ps
module sfb_frame_builder_test;
    import sfb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic        fifo_pop;
    logic        sync_req = 1'b0;
    logic        far_stop = 1'b0;
    logic [31:0] tx_data;
    logic [3:0]  tx_ctrl;

    always #2.5 clk = ~clk;

    sfb_frame_builder uut (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .sync_req(sync_req), .far_stop(far_stop),
        .tx_data(tx_data), .tx_ctrl(tx_ctrl)
    );

    // Bench FIFO model
    logic [31:0] mem [0:4095];
    logic [31:0] wr_ptr = 0;
    logic [31:0] rd_ptr = 0;
    logic [31:0] exp_ptr = 0;
    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_data  = mem[rd_ptr[11:0]];
    always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] a;
        a = c;
        for (int i = 31; i >= 0; i--) begin
            if (a[31] ^ d[i]) a = (a << 1) ^ 32'h04C1_1DB7;
            else              a = a << 1;
        end
        return a;
    endfunction

    function automatic bit is_idle();
        return (tx_ctrl == 4'b0001 && tx_data == 32'h9595_B5BC);
    endfunction

    task automatic push(input int n);
        for (int k = 0; k < n; k++) begin
            mem[wr_ptr[11:0]] = {wr_ptr[15:0], ~wr_ptr[15:0]} ^ 32'h5A00_00A5;
            wr_ptr = wr_ptr + 1;
        end
    endtask

    task automatic pulse_sync();
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
    endtask

    // Follows one frame on the output and checks every word of it
    task automatic expect_frame(input int kind, input int cnt, input string req, output int idles);
        int          waited = 0;
        int          got = 0;
        int          mism = 0;
        logic [31:0] crc = 32'hFFFF_FFFF;
        logic [31:0] bad_a = 0, bad_e = 0, tw;
        idles = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!(tx_ctrl == 4'b0001 && tx_data == 32'h3737_B5BC) && waited < 5000);
        check(waited < 5000, {req, " R3 start ordered set"}, tx_data, 32'h3737_B5BC);
        while (got < cnt && idles < 5000) begin
            @(negedge clk);
            if (is_idle()) idles++;
            else begin
                if (!(tx_ctrl == 4'b0000 && tx_data == mem[exp_ptr[11:0]])) begin
                    if (mism == 0) begin bad_a = tx_data; bad_e = mem[exp_ptr[11:0]]; end
                    mism++;
                end
                crc = crc_word(crc, mem[exp_ptr[11:0]]);
                exp_ptr = exp_ptr + 1;
                got++;
            end
        end
        check(mism == 0 && got == cnt, {req, " R3 R11 payload order and flags"}, bad_a, bad_e);
        do @(negedge clk); while (is_idle() && idles++ < 5000);
        tw = {16'(cnt), 14'b0, 2'(kind)};
        check(tx_ctrl == 4'b0000 && tx_data == tw, {req, " R4 type word"}, tx_data, tw);
        crc = crc_word(crc, tw);
        @(negedge clk);
        check(tx_ctrl == 4'b0000 && tx_data == ~crc, {req, " R5 CRC word"}, tx_data, ~crc);
        @(negedge clk);
        check(tx_ctrl == 4'b0001 && tx_data == 32'hF5F5_95BC, {req, " R3 end ordered set"}, tx_data, 32'hF5F5_95BC);
        @(negedge clk);
        check(is_idle(), {req, " R3 first gap idle"}, tx_data, 32'h9595_B5BC);
        @(negedge clk);
        check(is_idle(), {req, " R3 second gap idle"}, tx_data, 32'h9595_B5BC);
    endtask

    // words, sync, kind0, cnt0, kind1, cnt1 (kind1 = 0: single frame)
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{5,    1, 2, 5,   0, 0},    // R7 short sync frame
        '{1,    1, 2, 1,   0, 0},    // R7 one word
        '{0,    1, 3, 0,   0, 0},    // R8 bare sync
        '{512,  0, 1, 512, 0, 0},    // R6 exactly full
        '{600,  1, 1, 512, 2, 88},   // R6 R7 overflow into sync frame
        '{1024, 0, 1, 512, 1, 512}   // R6 two full frames
    };

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 0);
        finish_run();
    end

    initial begin
        int idl;
        int sofs;
        int pops;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(tx_data == 32'h9595_B5BC && tx_ctrl == 4'b0001, "R1 reset output idle", tx_data, 32'h9595_B5BC);
        check(fifo_pop == 1'b0, "R1 no pop in reset", 32'(fifo_pop), 0);
        rst_n = 1'b1;

        // R2: nothing to do
        pops = 0; sofs = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (!is_idle()) sofs++;
            if (fifo_pop) pops++;
        end
        check(sofs == 0, "R2 idle stream", 32'(sofs), 0);
        check(pops == 0, "R2 no pop when empty", 32'(pops), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            fork
                begin
                    push(VEC[v][0]);
                    if (VEC[v][1] != 0) pulse_sync();
                end
                begin
                    expect_frame(VEC[v][2], VEC[v][3], $sformatf("vec%0d", v), idl);
                    if (VEC[v][4] != 0)
                        expect_frame(VEC[v][4], VEC[v][5], $sformatf("vec%0d second", v), idl);
                end
            join
            repeat (4) @(negedge clk);
        end
        check(rd_ptr == wr_ptr, "R6 all words consumed", rd_ptr, wr_ptr);

        // R9: FIFO runs dry mid-frame without sync
        fork
            begin
                push(3);
                repeat (12) @(negedge clk);
                push(2);
                pulse_sync();
            end
            expect_frame(2, 5, "R9", idl);
        join
        check(idl > 0, "R9 idles inside open frame", 32'(idl), 1);
        repeat (4) @(negedge clk);

        // R10: stop holds off a new frame
        far_stop = 1'b1;
        push(4);
        pulse_sync();
        sofs = 0; pops = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (tx_ctrl == 4'b0001 && tx_data == 32'h3737_B5BC) sofs++;
            if (fifo_pop) pops++;
        end
        check(sofs == 0, "R10 no start while stopped", 32'(sofs), 0);
        check(pops == 0, "R10 no pop while stopped", 32'(pops), 0);
        fork
            far_stop = 1'b0;
            expect_frame(2, 4, "R10 after release", idl);
        join
        repeat (4) @(negedge clk);

        // R10: stop during an open frame lets it finish
        fork
            begin
                push(3);
                repeat (8) @(negedge clk);
                far_stop = 1'b1;
                pulse_sync();
            end
            expect_frame(2, 3, "R10 in progress", idl);
        join
        far_stop = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule